// File: doc/BRIEF.md
# Rotate-Left-Through-Carry Execution Slice

This block executes one instruction: a single-bit left rotate of an 8-bit data-memory byte through the carry flag. It decodes a 16-bit instruction word. It forms a 12-bit data-memory address from an 8-bit file address, using either a fixed access bank or the current bank-select value. It reads the operand, rotates it and writes the result. The destination is either the working register or the same memory byte, chosen by a bit in the instruction. It also produces new carry, negative and zero flags.

Each instruction cycle is split into four internal phases, numbered 0 to 3: decode, read, process, write. A free-running phase counter steps through them, and `phase_o` shows the current one. The caller presents the instruction, bank select and incoming carry during phase 0. The block samples them on the clock edge that ends phase 0. Memory is asynchronous-read: `mem_rdata_i` must reflect `mem_addr_o` within the read phase. All result strobes appear during phase 3.

Top module: `rlc_exec_unit`

## Requirements
- R1: Only words with bits [15:10] = 001101 execute. Any other word produces no memory read, no memory write, no working-register write and no flag strobe, and leaves the flag outputs and memory unchanged.
- R2: The result is {operand[6:0], carry_in}, where carry_in is the value of `c_i` sampled at the end of phase 0.
- R3: The new carry `c_o` equals operand bit 7.
- R4: `n_o` equals result bit 7, and `z_o` is 1 exactly when the 8-bit result is zero.
- R5: With bit 9 = 0, `w_we_o` pulses in phase 3 with `w_o` = result. `mem_we_o` stays low, so the memory byte keeps its value.
- R6: With bit 9 = 1, `mem_we_o` pulses in phase 3 only, at the same address that was read, with `mem_wdata_o` = result. `w_we_o` stays low.
- R7: With bit 8 = 0, file addresses 00h to 5Fh map to {0h, f} and 60h to FFh map to {Fh, f}.
- R8: With bit 8 = 1, the address is {bsr[3:0], f}, where bsr is sampled at the end of phase 0.
- R9: `phase_o` cycles 0, 1, 2, 3, 0, and so on. `mem_re_o` is high only in phase 1, and no write strobe appears outside phase 3.
- R10: `flag_we_o` is high in phase 3 of each executed instruction. The flag outputs hold their values between executed instructions.
- R11: After reset, `phase_o` = 0, all strobes are low and `c_o`, `n_o`, `z_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word, sampled at end of phase 0 |
| bsr_i | input | 4 | Bank select, sampled at end of phase 0 |
| c_i | input | 1 | Incoming carry, sampled at end of phase 0 |
| phase_o | output | 2 | Current phase (0 decode, 1 read, 2 process, 3 write) |
| mem_addr_o | output | 12 | Data-memory address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Memory read data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| w_o | output | 8 | Result toward the working register |
| w_we_o | output | 1 | Working-register write strobe |
| flag_we_o | output | 1 | Flag update strobe |
| c_o | output | 1 | New carry |
| n_o | output | 1 | New negative flag |
| z_o | output | 1 | New zero flag |

## Verification
A wrong internal state shows at the ports within the same instruction cycle in which it arises. A phase counter out of step moves the read or write strobes into the wrong phase at once. A bad address latch shows as a wrong `mem_addr_o` in phase 1. A wrong operand or carry capture shows as a wrong `w_o`, `mem_wdata_o` or `c_o` two phases later. A write sent to the wrong destination leaves a stale or corrupted memory byte, which is visible as soon as the next phase 0 begins.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int DATA_W  = 8;
  localparam int FILE_W  = 8;
  localparam int BANK_W  = 4;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 6;
  localparam int ADDR_W  = BANK_W + FILE_W;

  localparam logic [OPC_W-1:0] OPC_RLC = 6'b001101;

  typedef enum logic [1:0] {
    PH_DECODE = 2'd0,
    PH_READ   = 2'd1,
    PH_PROC   = 2'd2,
    PH_WRITE  = 2'd3
  } phase_e;

  typedef struct packed {
    logic              valid;
    logic              to_file;
    logic              banked;
    logic [FILE_W-1:0] faddr;
  } dec_t;
endpackage

// File: rtl/rlc_decode.sv
module rlc_decode
  import rlc_pkg::*;
#(
  parameter int INSTR_WIDTH = INSTR_W
) (
  input  logic [INSTR_WIDTH-1:0] instr_i,
  output dec_t                   dec_o
);
  localparam int OPC_LSB = INSTR_WIDTH - OPC_W;

  always_comb begin
    dec_o.valid   = (instr_i[INSTR_WIDTH-1:OPC_LSB] == OPC_RLC);
    dec_o.to_file = instr_i[FILE_W+1];
    dec_o.banked  = instr_i[FILE_W];
    dec_o.faddr   = instr_i[FILE_W-1:0];
  end
endmodule

// File: rtl/rlc_bank_addr.sv
module rlc_bank_addr #(
  parameter int                  F_W         = 8,
  parameter int                  B_W         = 4,
  parameter logic [F_W-1:0]      ACC_SPLIT   = 8'h60,
  parameter logic [B_W-1:0]      ACC_HI_BANK = 4'hF,
  localparam int                 A_W         = F_W + B_W
) (
  input  logic [F_W-1:0] faddr_i,
  input  logic           banked_i,
  input  logic [B_W-1:0] bsr_i,
  output logic [A_W-1:0] addr_o
);
  logic [B_W-1:0] bank;

  always_comb begin
    if (banked_i)                 bank = bsr_i;
    else if (faddr_i < ACC_SPLIT) bank = '0;
    else                          bank = ACC_HI_BANK;
    addr_o = {bank, faddr_i};
  end
endmodule

// File: rtl/rlc_rotate.sv
module rlc_rotate #(
  parameter int W = 8
) (
  input  logic [W-1:0] opnd_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         n_o,
  output logic         z_o
);
  assign res_o[0] = c_i;
  for (genvar i = 1; i < W; i++) begin : g_shift
    assign res_o[i] = opnd_i[i-1];
  end
  assign c_o = opnd_i[W-1];
  assign n_o = res_o[W-1];
  assign z_o = ~|res_o;
endmodule

// File: rtl/rlc_sequencer.sv
module rlc_sequencer
  import rlc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_o
);
  phase_e ph_q, ph_d;

  always_comb begin
    unique case (ph_q)
      PH_DECODE: ph_d = PH_READ;
      PH_READ:   ph_d = PH_PROC;
      PH_PROC:   ph_d = PH_WRITE;
      default:   ph_d = PH_DECODE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_DECODE;
    else         ph_q <= ph_d;
  end

  assign phase_o = ph_q;

  assert_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_WRITE) |=> (ph_q == PH_DECODE));
  assert_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_READ) |=> (ph_q == PH_PROC));
endmodule

// File: rtl/rlc_exec_unit.sv
module rlc_exec_unit
  import rlc_pkg::*;
#(
  parameter int                DW          = DATA_W,
  parameter int                FW          = FILE_W,
  parameter int                BW          = BANK_W,
  parameter int                IW          = INSTR_W,
  parameter logic [FW-1:0]     ACC_SPLIT   = 8'h60,
  parameter logic [BW-1:0]     ACC_HI_BANK = 4'hF,
  localparam int               AW          = FW + BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] instr_i,
  input  logic [BW-1:0] bsr_i,
  input  logic          c_i,
  output logic [1:0]    phase_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_re_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [DW-1:0] w_o,
  output logic          w_we_o,
  output logic          flag_we_o,
  output logic          c_o,
  output logic          n_o,
  output logic          z_o
);
  phase_e         ph;
  dec_t           dec, ir_q;
  logic [BW-1:0]  bsr_q;
  logic           cin_q;
  logic [DW-1:0]  opnd_q, res_q, rot_res;
  logic           rot_c, rot_n, rot_z;
  logic           c_q, n_q, z_q;

  rlc_sequencer u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (ph)
  );

  rlc_decode #(.INSTR_WIDTH(IW)) u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  rlc_bank_addr #(
    .F_W(FW), .B_W(BW), .ACC_SPLIT(ACC_SPLIT), .ACC_HI_BANK(ACC_HI_BANK)
  ) u_addr (
    .faddr_i  (ir_q.faddr),
    .banked_i (ir_q.banked),
    .bsr_i    (bsr_q),
    .addr_o   (mem_addr_o)
  );

  rlc_rotate #(.W(DW)) u_rot (
    .opnd_i (opnd_q),
    .c_i    (cin_q),
    .res_o  (rot_res),
    .c_o    (rot_c),
    .n_o    (rot_n),
    .z_o    (rot_z)
  );

  // instruction, bank and carry are captured once per cycle, held to Q4
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q   <= '0;
      bsr_q  <= '0;
      cin_q  <= 1'b0;
      opnd_q <= '0;
      res_q  <= '0;
      c_q    <= 1'b0;
      n_q    <= 1'b0;
      z_q    <= 1'b0;
    end else begin
      unique case (ph)
        PH_DECODE: begin
          ir_q  <= dec;
          bsr_q <= bsr_i;
          cin_q <= c_i;
        end
        PH_READ: if (ir_q.valid) opnd_q <= mem_rdata_i;
        PH_PROC: if (ir_q.valid) begin
          res_q <= rot_res;
          c_q   <= rot_c;
          n_q   <= rot_n;
          z_q   <= rot_z;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    mem_re_o  = (ph == PH_READ)  && ir_q.valid;
    flag_we_o = (ph == PH_WRITE) && ir_q.valid;
    mem_we_o  = flag_we_o &&  ir_q.to_file;
    w_we_o    = flag_we_o && !ir_q.to_file;
  end

  assign phase_o     = ph;
  assign mem_wdata_o = res_q;
  assign w_o         = res_q;
  assign c_o         = c_q;
  assign n_o         = n_q;
  assign z_o         = z_q;

  assert_rotate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> (w_o[DW-1:1] == $past(mem_rdata_i[DW-2:0], 2)) && (w_o[0] == $past(c_i, 3)));
  assert_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> (c_o == $past(mem_rdata_i[DW-1], 2)));
  assert_nz_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> (n_o == w_o[DW-1]) && (z_o == (w_o == '0)));
  assert_excl_dest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_we_o && mem_we_o));
  assert_same_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $stable(mem_addr_o) && $past(mem_re_o, 2));
  assert_read_phase_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (phase_o == 2'd1));
  assert_write_phase_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || w_we_o || flag_we_o) |-> (phase_o == 2'd3));
  assert_flag_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(flag_we_o) && (phase_o != 2'd3) |-> $stable({c_o, n_o, z_o}));
endmodule

// File: tb/rlc_exec_unit_test.sv
module rlc_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr_i = '0;
  logic [3:0]  bsr_i = '0;
  logic        c_i = 1'b0;
  logic [1:0]  phase_o;
  logic [11:0] mem_addr_o;
  logic        mem_re_o, mem_we_o, w_we_o, flag_we_o, c_o, n_o, z_o;
  logic [7:0]  mem_rdata_i, mem_wdata_o, w_o;

  logic [7:0]  mem [4096];
  logic        tb_we = 1'b0;
  logic [11:0] tb_addr = '0;
  logic [7:0]  tb_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rlc_exec_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr_i), .bsr_i(bsr_i), .c_i(c_i),
    .phase_o(phase_o), .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o),
    .mem_rdata_i(mem_rdata_i), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .w_o(w_o), .w_we_o(w_we_o), .flag_we_o(flag_we_o),
    .c_o(c_o), .n_o(n_o), .z_o(z_o)
  );

  assign mem_rdata_i = mem[mem_addr_o];
  always @(posedge clk) begin
    if (mem_we_o)   mem[mem_addr_o] <= mem_wdata_o;
    else if (tb_we) mem[tb_addr]    <= tb_data;
  end

  function automatic logic [11:0] exp_addr(input logic [15:0] ins, input logic [3:0] bsr);
    if (ins[8])               return {bsr, ins[7:0]};
    else if (ins[7:0] < 8'h60) return {4'h0, ins[7:0]};
    else                       return {4'hF, ins[7:0]};
  endfunction

  function automatic logic [8:0] exp_rot(input logic [7:0] d, input logic c);
    return {d, c};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // caller is at a negedge in phase 0
  task automatic run_op(input logic [15:0] ins, input logic [3:0] bsr, input logic c, input logic [7:0] data);
    logic       rot = (ins[15:10] == 6'b001101);
    logic [11:0] ea = exp_addr(ins, bsr);
    logic [8:0] r   = exp_rot(data, c);
    logic [7:0] res = r[7:0];
    logic       co  = r[8];
    logic [2:0] pf  = {c_o, n_o, z_o};
    chk(phase_o == 2'd0, "R9 phase0", phase_o, 0);
    instr_i = ins; bsr_i = bsr; c_i = c;
    tb_we = 1'b1; tb_addr = ea; tb_data = data;
    @(negedge clk);
    tb_we = 1'b0;
    chk(phase_o == 2'd1, "R9 phase1", phase_o, 1);
    if (rot) begin
      chk(mem_re_o == 1'b1, "R9 read strobe", mem_re_o, 1);
      chk(mem_addr_o == ea, ins[8] ? "R8 banked addr" : "R7 access addr", mem_addr_o, ea);
    end else chk(mem_re_o == 1'b0, "R1 no read", mem_re_o, 0);
    @(negedge clk);
    chk(!mem_we_o && !w_we_o && !flag_we_o && !mem_re_o, "R9 phase2 quiet",
        {mem_we_o, w_we_o, flag_we_o, mem_re_o}, 0);
    @(negedge clk);
    chk(phase_o == 2'd3, "R9 phase3", phase_o, 3);
    if (rot) begin
      chk(flag_we_o == 1'b1, "R10 flag strobe", flag_we_o, 1);
      chk(c_o == co, "R3 carry", c_o, co);
      chk({n_o, z_o} == {res[7], res == 8'h00}, "R4 n/z", {n_o, z_o}, {res[7], res == 8'h00});
      if (ins[9]) begin
        chk(mem_we_o && !w_we_o, "R6 strobes", {mem_we_o, w_we_o}, 2'b10);
        chk(mem_wdata_o == res, "R2 file result", mem_wdata_o, res);
        chk(mem_addr_o == ea, "R6 write addr", mem_addr_o, ea);
      end else begin
        chk(w_we_o && !mem_we_o, "R5 strobes", {mem_we_o, w_we_o}, 2'b01);
        chk(w_o == res, "R2 W result", w_o, res);
      end
    end else begin
      chk(!mem_we_o && !w_we_o && !flag_we_o, "R1 no strobes",
          {mem_we_o, w_we_o, flag_we_o}, 0);
      chk({c_o, n_o, z_o} == pf, "R1 flags kept", {c_o, n_o, z_o}, pf);
    end
    @(negedge clk);
    if (rot && ins[9]) chk(mem[ea] == res, "R6 memory", mem[ea], res);
    else chk(mem[ea] == data, rot ? "R5 memory kept" : "R1 memory kept", mem[ea], data);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(phase_o == 2'd0 && !mem_re_o && !mem_we_o && !w_we_o && !flag_we_o,
        "R11 reset strobes", {phase_o, mem_re_o, mem_we_o, w_we_o, flag_we_o}, 0);
    chk({c_o, n_o, z_o} == 3'b000, "R11 reset flags", {c_o, n_o, z_o}, 0);
    rst_ni = 1'b1;
    // directed corners
    run_op(16'h3422, 4'h0, 1'b0, 8'hE6);    // R2 example: W=CC, C=1
    run_op(16'h3610, 4'h0, 1'b0, 8'h00);    // R4 zero, file dest
    run_op(16'h3410, 4'h0, 1'b0, 8'h80);    // R4 zero with carry out
    run_op(16'h3440, 4'h0, 1'b1, 8'h7F);    // R4 negative
    run_op(16'h365F, 4'h7, 1'b1, 8'h55);    // R7 below split
    run_op(16'h3660, 4'h7, 1'b0, 8'hAA);    // R7 at split
    run_op(16'h34FF, 4'h7, 1'b1, 8'h01);    // R7 top
    run_op(16'h3705, 4'h3, 1'b0, 8'h91);    // R8 banked
    run_op(16'h35FF, 4'hF, 1'b1, 8'hFF);    // R8 banked top
    run_op(16'h3A22, 4'h0, 1'b1, 8'h12);    // R1 neighbour opcode
    run_op(16'h0012, 4'h1, 1'b0, 8'h34);    // R1 other word
    for (int k = 0; k < 400; k++) begin
      logic [15:0] ins = 16'($urandom);
      if ($urandom % 10 < 7) ins[15:10] = 6'b001101;
      run_op(ins, 4'($urandom), 1'($urandom), 8'($urandom));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule